// File: doc/BRIEF.md
# Bidirectional Four-Pin Port with Direction Control

This block is a small general-purpose I/O port hung on a simple memory-mapped register bus. Two registers, an output latch and a direction mask, decide what each of the four pins does. A pin whose direction bit is set is driven from its latch bit. A pin whose direction bit is clear is left undriven, and software can observe its level.

A read of the latch address returns a per-bit blend. Pins in output mode report the stored latch bit. Pins in input mode report the pin level after it has passed through a two-flop synchronizer.

Every register write takes two states. In the first state the bus value is captured into a staging stage, and the pins and the read-back still show the previous contents. On the clock edge that ends the second state the staged value is committed to its register, and the pins move on that edge. A new write may follow immediately, so back-to-back writes commit one per cycle.

Top module: `bidir_port`

## Requirements
- R1: Reset (synchronous, active low) clears the output latch and the direction mask, so `pin_out` and `pin_oe` are 0 and a read of the direction address returns 0.
- R2: The output latch answers at bus address 0x0B and the direction mask at 0x0C. A write to any other address changes no output, and a read of any other address returns 0.
- R3: `pin_oe[i]` equals direction bit i (1 = output, 0 = tri-stated), and `pin_out` carries the output latch.
- R4: A read of address 0x0B returns latch bit i for every pin whose direction bit is 1.
- R5: A read of address 0x0B returns the synchronized level of `pin_in[i]` for every pin whose direction bit is 0. A pin change is first visible two rising edges after it is applied.
- R6: A write strobe sampled on edge e captures the value. `pin_out`, `pin_oe` and the read-back keep their old values until edge e+1 commits the new value.
- R7: A write to the latch while a pin is in input mode still stores the bit, and that bit appears on `pin_out` and in the read-back once the pin's direction is switched to output.
- R8: Strobes on consecutive cycles each commit exactly one edge after their own capture edge, in issue order.
- R9: A read of address 0x0C returns the committed direction mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Combinational read data for `bus_addr` |
| pin_in | input | 4 | Pin levels seen from the pads |
| pin_out | output | 4 | Value driven to the pads |
| pin_oe | output | 4 | Per-pin driver enable, 0 = tri-stated |

## Verification
A staging stage that is stuck, or that commits early, shows at the pins within one or two edges of the write strobe. The pins then move on the capture edge, or never move at all. A wrong direction bit shows at once on `pin_oe`. It also flips the affected read-back bit between latch and pin, so a sweep over every pairing of direction mask and latch value, with the pin levels chosen to differ from the latch, makes any mux swap visible on the first read. A synchronizer with the wrong depth shows as a read-back change one edge too early or too late after a pin toggle.

// File: rtl/bport_pkg.sv
// Shared definitions for the bidirectional port.
// Assumes: a single register bus, one target selected per access.
package bport_pkg;

    // Which register a bus access targets
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } bport_sel_e;

endpackage

// File: rtl/bport_decode.sv
// Address decoder: maps a bus address to a register select.
// Assumes: DATA_ADDR and DIR_ADDR differ; any other address selects nothing.
module bport_decode
    import bport_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_ADDR = 8'h0B,
    parameter int DIR_ADDR  = 8'h0C
) (
    input  logic [ADDR_W-1:0] addr,
    output bport_sel_e        sel
);

    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_ADDR);

    // Compare the address against both register slots
    always_comb begin
        if (addr == DATA_A)     sel = SEL_DATA;
        else if (addr == DIR_A) sel = SEL_DIR;
        else                    sel = SEL_NONE;
    end

endmodule

// File: rtl/bport_wr_seq.sv
// Two-state write sequencer holding the output latch and direction mask.
// State 1: the strobe edge loads the staging stage. State 2: the next edge
// commits the staged value to the selected register. The staging stage
// reloads every cycle, so back-to-back strobes commit one per cycle.
// Assumes: wr_en is a single-cycle strobe per write.
module bport_wr_seq
    import bport_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  bport_sel_e       sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);

    logic             stg_vld;
    bport_sel_e       stg_sel;
    logic [WIDTH-1:0] stg_val;

    // State 1: capture the strobe target and value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld <= 1'b0;
            stg_sel <= SEL_NONE;
            stg_val <= '0;
        end else begin
            stg_vld <= wr_en && (sel != SEL_NONE);
            stg_sel <= sel;
            stg_val <= wdata;
        end
    end

    // State 2: commit the staged value to its register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (stg_vld) begin
            case (stg_sel)
                SEL_DATA: latch_q <= stg_val;
                SEL_DIR:  dir_q   <= stg_val;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/bport_in_sync.sv
// Multi-flop synchronizer for the pin inputs, one chain per pin.
// Assumes: STAGES >= 1; the chain is cleared by reset.
module bport_in_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
        if (gs == 0) begin : g_first
            // First flop samples the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gs] <= '0;
                else        chain[gs] <= pin_in;
            end
        end else begin : g_next
            // Later flops shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gs] <= '0;
                else        chain[gs] <= chain[gs-1];
            end
        end
    end

    assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/bport_rd_mux.sv
// Read-back multiplexer. The latch address yields a per-bit blend (latch when
// the pin drives, synchronized pin level when it does not); the direction
// address yields the mask; anything else yields zero.
// Assumes: purely combinational, read data valid in the same cycle.
module bport_rd_mux
    import bport_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  bport_sel_e       sel,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] blend;

    for (genvar gb = 0; gb < WIDTH; gb++) begin : g_bit
        // Per-pin source choice by direction
        assign blend[gb] = dir_q[gb] ? latch_q[gb] : pin_sync[gb];
    end

    // Select the register being read
    always_comb begin
        case (sel)
            SEL_DATA: rdata = blend;
            SEL_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/bidir_port.sv
// Top of the bidirectional port: decode, two-state write sequencer,
// input synchronizer and read-back multiplexer.
// Assumes: the pad ring combines pin_out and pin_oe into a tri-state driver.
module bidir_port
    import bport_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int ADDR_W      = 8,
    parameter int DATA_ADDR   = 8'h0B,
    parameter int DIR_ADDR    = 8'h0C,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);

    bport_sel_e       sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    bport_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_ADDR(DATA_ADDR),
        .DIR_ADDR (DIR_ADDR)
    ) decode_i (
        .addr(bus_addr),
        .sel (sel)
    );

    bport_wr_seq #(
        .WIDTH(WIDTH)
    ) wr_seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .sel    (sel),
        .wdata  (bus_wdata),
        .latch_q(latch_q),
        .dir_q  (dir_q)
    );

    bport_in_sync #(
        .WIDTH (WIDTH),
        .STAGES(SYNC_STAGES)
    ) in_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .pin_sync(pin_sync)
    );

    bport_rd_mux #(
        .WIDTH(WIDTH)
    ) rd_mux_i (
        .sel     (sel),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pin_sync(pin_sync),
        .rdata   (bus_rdata)
    );

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/bport_chk.sv
// Port-level property checker for bidir_port, attached by bind.
// Assumes: a two-flop input synchronizer (default configuration).
module bport_chk #(
    parameter int WIDTH     = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_ADDR = 8'h0B,
    parameter int DIR_ADDR  = 8'h0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_in,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe
);

    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_ADDR);

    logic [1:0] warm;

    // Count edges since reset release, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0));

    a_r2_other_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != DATA_A && bus_addr != DIR_A) |-> (bus_rdata == '0));

    a_r6_data_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_A) |=> ##1 (pin_out == $past(bus_wdata, 2)));

    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DATA_A) |=> ##1 $stable(pin_out));

    a_r3_dir_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_A) |=> ##1 (pin_oe == $past(bus_wdata, 2)));

    a_r4_out_bits_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DATA_A) |-> ((bus_rdata & pin_oe) == (pin_out & pin_oe)));

    a_r5_in_bits_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DATA_A && warm == 2'd2) |->
            ((bus_rdata & ~pin_oe) == ($past(pin_in, 2) & ~pin_oe)));

    a_r9_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DIR_A) |-> (bus_rdata == pin_oe));

endmodule

bind bidir_port bport_chk #(
    .WIDTH    (WIDTH),
    .ADDR_W   (ADDR_W),
    .DATA_ADDR(DATA_ADDR),
    .DIR_ADDR (DIR_ADDR)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/bidir_port_tb_top.sv
`timescale 1ns/1ps
module bidir_port_tb_top;

    localparam logic [7:0] A_DATA = 8'h0B;
    localparam logic [7:0] A_DIR  = 8'h0C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = 4'h0;
    logic [3:0] bus_rdata;
    logic [3:0] pin_in = 4'h0;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bidir_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Full write: strobe, pass S1 edge, pass S2 edge; returns at a negedge
    task automatic wr_full(input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [3:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pin_out", pin_out, 4'h0);
        chk("R1 pin_oe", pin_oe, 4'h0);
        rd(A_DIR, r);  chk("R1 dir read", r, 4'h0);

        // R6: old values during S1, new after S2 (data and direction)
        @(negedge clk);
        bus_addr = A_DIR; bus_wr = 1'b1; bus_wdata = 4'hF;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R6 oe held in S1", pin_oe, 4'h0);
        @(negedge clk);
        chk("R3 oe after S2", pin_oe, 4'hF);
        bus_addr = A_DATA; bus_wr = 1'b1; bus_wdata = 4'hA;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R6 pin_out held in S1", pin_out, 4'h0);
        rd(A_DATA, r); chk("R6 read old in S1", r, 4'h0);
        @(negedge clk);
        chk("R6 pin_out after S2", pin_out, 4'hA);
        rd(A_DATA, r); chk("R6 read new after S2", r, 4'hA);

        // R8: back-to-back strobes
        bus_addr = A_DATA; bus_wr = 1'b1; bus_wdata = 4'h3;
        @(negedge clk);
        bus_wdata = 4'h9;
        chk("R8 first still old", pin_out, 4'hA);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8 first committed", pin_out, 4'h3);
        @(negedge clk);
        chk("R8 second committed", pin_out, 4'h9);

        // R2: unmapped address ignored on write, reads zero
        wr_full(8'h05, 4'h6);
        chk("R2 pin_out unchanged", pin_out, 4'h9);
        chk("R2 pin_oe unchanged", pin_oe, 4'hF);
        rd(8'h05, r); chk("R2 unmapped read", r, 4'h0);
        rd(8'h0A, r); chk("R2 unmapped read 0A", r, 4'h0);

        // R5: input latency of two edges
        wr_full(A_DIR, 4'h0);
        pin_in = 4'h0;
        repeat (3) @(negedge clk);
        pin_in = 4'hC;
        @(negedge clk);
        rd(A_DATA, r); chk("R5 one edge old", r, 4'h0);
        @(negedge clk);
        rd(A_DATA, r); chk("R5 two edges new", r, 4'hC);

        // R7: write while input, then switch to output
        pin_in = 4'h0;
        wr_full(A_DATA, 4'h5);
        @(negedge clk);
        rd(A_DATA, r); chk("R7 input mode shows pin", r, 4'h0);
        chk("R7 latch on pin_out", pin_out, 4'h5);
        chk("R7 undriven", pin_oe, 4'h0);
        wr_full(A_DIR, 4'hF);
        rd(A_DATA, r); chk("R7 latch read after switch", r, 4'h5);
        rd(A_DIR, r);  chk("R9 dir read", r, 4'hF);

        // R3/R4/R5/R9: sweep every direction mask and latch value
        for (int dr = 0; dr < 16; dr++) begin
            wr_full(A_DIR, 4'(dr));
            for (int d = 0; d < 16; d++) begin
                logic [3:0] pv, exp;
                pv = 4'((d * 5 + dr * 3 + 1) ^ 4'hF);
                pin_in = pv;
                wr_full(A_DATA, 4'(d));
                exp = (4'(dr) & 4'(d)) | (~4'(dr) & pv);
                rd(A_DATA, r); chk("R4/R5 blended read", r, exp);
                chk("R3 pin_out", pin_out, 4'(d));
                chk("R3 pin_oe", pin_oe, 4'(dr));
            end
            rd(A_DIR, r); chk("R9 dir sweep", r, 4'(dr));
        end

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset pin_out", pin_out, 4'h0);
        chk("R1 re-reset pin_oe", pin_oe, 4'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule